// File: doc/BRIEF.md
# Per-Channel Zero Code Suppression Inserter

This block sits on a T1 transmit path, after signaling has been placed into the bytes, and keeps the line's ones density up. Each DS0 byte arrives with its channel number (0 to 23) and a marker that tells whether the current frame is a signaling frame. A small per-channel table picks the substitution rule for that byte. The modified byte leaves exactly one clock later, with its channel number and frame marker still aligned to it.

Bits are numbered 1 to 8, from the most significant to the least significant. Bit 1 is `data[7]` and is sent first. Bit 7 is `data[1]`. Bit 8 is `data[0]`. The table holds one 2-bit code per channel:

- `00`: off.
- `01`: bit-7 stuffing.
- `10`: GTE-style stuffing.
- `11`: jammed bit 8.

The table is loaded through a simple write strobe. A channel number above 23 on the data side is passed through untouched.

Top module: `zcs_inserter`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `out_valid` is 0 and `out_data` is 0x00. Every table entry resets to code 00 (off).
- R2: Each byte accepted with `in_valid`=1 appears one clock later with `out_valid`=1. `out_chan` and `out_sigframe` in that cycle equal the values that came in with the byte. A cycle with `in_valid`=0 gives `out_valid`=0 one clock later.
- R3: For a channel whose code is 00, `out_data` equals `in_data` for every byte, including 0x00.
- R4: Code 01 turns an all-zero byte into 0x02 (bit 7 set). Any non-zero byte passes unchanged, whatever the frame.
- R5: Code 10 turns an all-zero byte in a frame with `in_sigframe`=0 into 0x01 (bit 8 set). Any non-zero byte passes unchanged.
- R6: Code 10 turns an all-zero byte in a frame with `in_sigframe`=1 into 0x02 (bit 7 set).
- R7: Code 11 sets bit 8 (`data[0]`) of every byte of the channel, zero or not, and leaves the other bits as they are.
- R8: A write with `cfg_we`=1 stores `cfg_mode` for `cfg_chan` on that clock edge. Bytes accepted from the next edge on use the new code. Other channels keep their codes.
- R9: A write whose `cfg_chan` is 24 or higher changes no entry.
- R10: A byte whose `in_chan` is 24 or higher passes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_chan | input | 5 | Channel whose code is written |
| cfg_mode | input | 2 | Code to store (00 off, 01 bit 7, 10 GTE, 11 jam bit 8) |
| in_valid | input | 1 | Input byte is present |
| in_data | input | 8 | DS0 byte, bit 1 in `in_data[7]` |
| in_chan | input | 5 | Channel number of the input byte |
| in_sigframe | input | 1 | Current frame carries robbed-bit signaling |
| out_valid | output | 1 | Output byte is present |
| out_data | output | 8 | Byte after suppression |
| out_chan | output | 5 | Channel number, delayed with the data |
| out_sigframe | output | 1 | Signaling-frame marker, delayed with the data |

## Verification
The checker cannot see the table, so its properties are ones that hold for every code:

- an output byte only gains bits relative to its input;
- it gains at most one bit;
- any added bit is bit 7 or bit 8;
- a byte on an out-of-range channel is unchanged.

These properties assume that `in_valid` is held low while reset is asserted, because the latency checks compare against the cycle before. The stimulus keeps to this: it holds every input at zero through reset, mixes table writes and bytes on separate cycles, and draws channels from 0 to 31 so that out-of-range numbers appear.

// File: rtl/zcs_pkg.sv
// Package: shared types and bit positions for the zero code suppression inserter.
// Assumes bit 1 of a DS0 byte is the MSB (index 7) and bit 8 the LSB (index 0).
package zcs_pkg;

    // Per-channel substitution rule, encoded as stored in the table
    typedef enum logic [1:0] {
        ZCS_OFF  = 2'b00,
        ZCS_BIT7 = 2'b01,
        ZCS_GTE  = 2'b10,
        ZCS_JAM8 = 2'b11
    } zcs_mode_e;

    // Index in the byte vector of DS0 bit 7 and bit 8
    localparam int unsigned BIT7_IDX = 1;
    localparam int unsigned BIT8_IDX = 0;

endpackage

// File: rtl/zcs_mode_table.sv
// Module: zcs_mode_table
// Holds one 2-bit substitution code per channel and returns the code for the
// channel of the byte being processed. Writes to channels at or above CHANNELS
// are dropped. Reads of such channels return ZCS_OFF, so those bytes pass
// unchanged. Assumes a single write port; the read path is purely combinational.
module zcs_mode_table
    import zcs_pkg::*;
#(
    parameter int unsigned CHANNELS = 24,
    parameter int unsigned CHAN_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CHAN_W-1:0] wr_chan,
    input  zcs_mode_e         wr_mode,
    input  logic [CHAN_W-1:0] rd_chan,
    output zcs_mode_e         rd_mode
);

    zcs_mode_e entry_q [CHANNELS];

    // One register per channel, written only on an exact index match
    for (genvar gi = 0; gi < CHANNELS; gi++) begin : g_entry
        localparam logic [CHAN_W-1:0] MY_IDX = CHAN_W'(gi);

        // Update this entry on reset or on a write addressed to it
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry_q[gi] <= ZCS_OFF;
            end else if (wr_en && (wr_chan == MY_IDX)) begin
                entry_q[gi] <= wr_mode;
            end
        end
    end

    // Select the code of the requested channel, off when out of range
    always_comb begin
        rd_mode = ZCS_OFF;
        for (int i = 0; i < CHANNELS; i++) begin
            if (rd_chan == CHAN_W'(i)) begin
                rd_mode = entry_q[i];
            end
        end
    end

endmodule

// File: rtl/zcs_substitute.sv
// Module: zcs_substitute
// Combinational rule applied to one byte. Bit-7 and GTE stuffing act only on an
// all-zero byte. Jammed bit 8 acts on every byte. The input byte is assumed to
// already hold its robbed signaling bits, so the zero test sees the final byte.
module zcs_substitute
    import zcs_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  zcs_mode_e         mode,
    input  logic              sigframe,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    localparam logic [DATA_W-1:0] MASK_B7 = DATA_W'(1) << BIT7_IDX;
    localparam logic [DATA_W-1:0] MASK_B8 = DATA_W'(1) << BIT8_IDX;

    logic all_zero;

    // Detect a byte with no ones at all
    always_comb begin
        all_zero = (din == '0);
    end

    // Apply the selected substitution rule
    always_comb begin
        dout = din;
        unique case (mode)
            ZCS_OFF:  dout = din;
            ZCS_BIT7: if (all_zero) dout = MASK_B7;
            ZCS_GTE:  if (all_zero) dout = sigframe ? MASK_B7 : MASK_B8;
            ZCS_JAM8: dout = din | MASK_B8;
            default:  dout = din;
        endcase
    end

endmodule

// File: rtl/zcs_out_stage.sv
// Module: zcs_out_stage
// Single register stage that gives the block its fixed one-cycle latency and
// keeps channel number and frame marker aligned with the data. The data, channel
// and marker registers are loaded only for valid bytes; valid itself clears.
module zcs_out_stage #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CHAN_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              d_valid,
    input  logic [DATA_W-1:0] d_data,
    input  logic [CHAN_W-1:0] d_chan,
    input  logic              d_sig,
    output logic              q_valid,
    output logic [DATA_W-1:0] q_data,
    output logic [CHAN_W-1:0] q_chan,
    output logic              q_sig
);

    // Valid flag follows the input every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) q_valid <= 1'b0;
        else        q_valid <= d_valid;
    end

    // Payload registers capture only accepted bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_data <= '0;
            q_chan <= '0;
            q_sig  <= 1'b0;
        end else if (d_valid) begin
            q_data <= d_data;
            q_chan <= d_chan;
            q_sig  <= d_sig;
        end
    end

endmodule

// File: rtl/zcs_inserter.sv
// Module: zcs_inserter (top)
// Zero code suppression for a T1 transmit byte stream. Per-channel codes select
// off, bit-7, GTE or jammed-bit-8 stuffing. Output follows input by one clock.
// Assumes in_valid is low during reset and that signaling is already inserted.
module zcs_inserter
    import zcs_pkg::*;
#(
    parameter int unsigned CHANNELS = 24,
    parameter int unsigned CHAN_W   = 5,
    parameter int unsigned DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CHAN_W-1:0] cfg_chan,
    input  logic [1:0]        cfg_mode,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [CHAN_W-1:0] in_chan,
    input  logic              in_sigframe,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [CHAN_W-1:0] out_chan,
    output logic              out_sigframe
);

    zcs_mode_e             cur_mode;
    logic [DATA_W-1:0]     sub_data;

    zcs_mode_table #(
        .CHANNELS (CHANNELS),
        .CHAN_W   (CHAN_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_chan (cfg_chan),
        .wr_mode (zcs_mode_e'(cfg_mode)),
        .rd_chan (in_chan),
        .rd_mode (cur_mode)
    );

    zcs_substitute #(
        .DATA_W (DATA_W)
    ) u_sub (
        .mode     (cur_mode),
        .sigframe (in_sigframe),
        .din      (in_data),
        .dout     (sub_data)
    );

    zcs_out_stage #(
        .DATA_W (DATA_W),
        .CHAN_W (CHAN_W)
    ) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_valid (in_valid),
        .d_data  (sub_data),
        .d_chan  (in_chan),
        .d_sig   (in_sigframe),
        .q_valid (out_valid),
        .q_data  (out_data),
        .q_chan  (out_chan),
        .q_sig   (out_sigframe)
    );

endmodule

// File: rtl/zcs_inserter_checker.sv
// Module: zcs_inserter_checker
// Port-level properties of the inserter that hold for every table content.
// Assumes in_valid is low while rst_n is low.
module zcs_inserter_checker #(
    parameter int unsigned CHANNELS = 24,
    parameter int unsigned CHAN_W   = 5,
    parameter int unsigned DATA_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic [CHAN_W-1:0] in_chan,
    input logic              in_sigframe,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic [CHAN_W-1:0] out_chan,
    input logic              out_sigframe
);

    localparam logic [CHAN_W-1:0] FIRST_BAD = CHAN_W'(CHANNELS);
    localparam logic [DATA_W-1:0] LOW2_MASK = DATA_W'(3);

    // R2: an accepted byte yields a valid output one clock later
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: an idle input yields an idle output one clock later
    a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R2: the channel number and frame marker travel with the byte
    a_r2_side_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_chan == $past(in_chan)) && (out_sigframe == $past(in_sigframe)));

    // R4, R5, R6 and R7: substitution only ever adds ones
    a_r7_only_adds_ones: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((out_data & $past(in_data)) == $past(in_data)));

    // R4, R5, R6 and R7: at most one bit is changed per byte
    a_r6_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ($countones(out_data ^ $past(in_data)) <= 1));

    // R4 and R5: a changed bit is bit 7 or bit 8
    a_r5_bit_position: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (((out_data ^ $past(in_data)) & ~LOW2_MASK) == '0));

    // R10: an out-of-range channel passes unchanged
    a_r10_bad_chan_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_chan >= FIRST_BAD)) |=> (out_data == $past(in_data)));

endmodule

bind zcs_inserter zcs_inserter_checker #(
    .CHANNELS (CHANNELS),
    .CHAN_W   (CHAN_W),
    .DATA_W   (DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_data      (in_data),
    .in_chan      (in_chan),
    .in_sigframe  (in_sigframe),
    .out_valid    (out_valid),
    .out_data     (out_data),
    .out_chan     (out_chan),
    .out_sigframe (out_sigframe)
);

// File: tb/sim_zcs_inserter.sv
// Bench for zcs_inserter: directed corner cases, then seeded random traffic,
// checked against a table model kept in the bench.
module sim_zcs_inserter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_chan = '0;
    logic [1:0] cfg_mode = '0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic [4:0] in_chan = '0;
    logic       in_sigframe = 1'b0;
    logic       out_valid;
    logic [7:0] out_data;
    logic [4:0] out_chan;
    logic       out_sigframe;

    int n_run  = 0;
    int n_fail = 0;
    logic [1:0] model [24];

    always #5 clk = ~clk;

    zcs_inserter u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
        .cfg_mode(cfg_mode), .in_valid(in_valid), .in_data(in_data),
        .in_chan(in_chan), .in_sigframe(in_sigframe), .out_valid(out_valid),
        .out_data(out_data), .out_chan(out_chan), .out_sigframe(out_sigframe)
    );

    // Expected output byte from the written rules
    function automatic logic [7:0] expect_byte(input logic [4:0] ch, input logic [7:0] d,
                                               input logic sig);
        logic [1:0] m;
        if (ch >= 5'd24) return d;           // R10
        m = model[ch];
        case (m)
            2'b01:   return (d == 8'h00) ? 8'h02 : d;               // R4
            2'b10:   return (d == 8'h00) ? (sig ? 8'h02 : 8'h01) : d; // R5, R6
            2'b11:   return d | 8'h01;                            // R7
            default: return d;                                    // R3
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_mode(input logic [4:0] ch, input logic [1:0] m);
        @(negedge clk);
        cfg_we = 1'b1; cfg_chan = ch; cfg_mode = m;
        if (ch < 5'd24) model[ch] = m;       // R8, R9
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input string req, input logic [4:0] ch, input logic [7:0] d,
                        input logic sig);
        @(negedge clk);
        check("R2 idle", {31'd0, out_valid}, 32'd0);
        in_valid = 1'b1; in_chan = ch; in_data = d; in_sigframe = sig;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 valid", {31'd0, out_valid}, 32'd1);
        check("R2 chan", {27'd0, out_chan}, {27'd0, ch});
        check("R2 sig", {31'd0, out_sigframe}, {31'd0, sig});
        check(req, {24'd0, out_data}, {24'd0, expect_byte(ch, d, sig)});
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int seed;
        seed = 13;
        for (int i = 0; i < 24; i++) model[i] = 2'b00;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", {31'd0, out_valid}, 32'd0);
        check("R1 data in reset", {24'd0, out_data}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", {31'd0, out_valid}, 32'd0);
        check("R1 data after reset", {24'd0, out_data}, 32'd0);

        // R1 and R3: all channels off after reset, zero passes
        send("R1 table off", 5'd0, 8'h00, 1'b0);
        send("R3 off zero", 5'd23, 8'h00, 1'b1);

        write_mode(5'd3, 2'b01);
        send("R4 bit7 zero", 5'd3, 8'h00, 1'b0);
        send("R4 bit7 zero sig", 5'd3, 8'h00, 1'b1);
        send("R4 bit7 nonzero", 5'd3, 8'h80, 1'b0);

        write_mode(5'd7, 2'b10);
        send("R5 gte zero", 5'd7, 8'h00, 1'b0);
        send("R6 gte zero sig", 5'd7, 8'h00, 1'b1);
        send("R5 gte nonzero", 5'd7, 8'h10, 1'b1);

        write_mode(5'd23, 2'b11);
        send("R7 jam zero", 5'd23, 8'h00, 1'b0);
        send("R7 jam nonzero", 5'd23, 8'hA4, 1'b1);
        send("R7 jam bit8 set", 5'd23, 8'hFF, 1'b0);

        // R8: neighbouring channels unaffected, rewrite takes effect
        send("R8 neighbour off", 5'd4, 8'h00, 1'b0);
        write_mode(5'd3, 2'b00);
        send("R8 rewrite off", 5'd3, 8'h00, 1'b0);

        // R9: out-of-range writes must not alias into channels 0 and 8
        write_mode(5'd24, 2'b11);
        write_mode(5'd31, 2'b01);
        send("R9 no alias ch0", 5'd0, 8'h00, 1'b0);
        send("R9 no alias ch8", 5'd8, 8'h00, 1'b0);
        send("R9 no alias ch7", 5'd7, 8'h00, 1'b0);

        // R10: out-of-range channels pass unchanged
        send("R10 bad chan zero", 5'd24, 8'h00, 1'b0);
        send("R10 bad chan 31", 5'd31, 8'h00, 1'b1);

        // Random traffic mixed with random table writes
        void'($urandom(seed));
        for (int k = 0; k < 2000; k++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[3:0] == 4'd0) begin
                write_mode(r[8:4], r[10:9]);
            end else begin
                send("R8 random", r[8:4], r[11] ? 8'h00 : r[19:12], r[20]);
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule